// File: doc/BRIEF.md
# Double-Buffered Asymmetric PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter. The counter walks from zero to one less than a programmed period and wraps. A compare value splits each period into an active part and an idle part. A polarity bit picks whether the active part is driven high or low. A mode bit gates the whole output. When the mode bit is clear, the pin stays low.

Software programs the block through a small byte-addressed register window. The window accepts 32-bit and 16-bit accesses. There are two ways to change the waveform. A write to the live period or compare register takes effect at once. A write to the matching staging register is held back until the counter next wraps, so the period in progress always runs to its end. The staged values are then copied into the live registers on that same clock edge.

Top module: `apwm_shadow`

## Requirements
- R1: After reset every register reads zero, the counter is stopped at zero, no staged transfer is pending and the output is low.
- R2: The live period sits at byte offset 0x08, the live compare at 0x0C, the staged period at 0x10 and the staged compare at 0x14. Each is 32 bits wide and reads back what was last stored in it. Unmapped offsets read zero and ignore writes.
- R3: The 16-bit control register sits at byte offset 0x2A. Bit 4 is the run bit, bits 7:6 are the sync-select field, bit 9 is the mode enable and bit 10 is the polarity select. All other bits are not stored and read as zero.
- R4: With `bus_wide`=1 the access is 32 bits. Address bits 1:0 must be 0, and a wide access at 0x28 reaches the control register in data bits 31:16. With `bus_wide`=0 the access is 16 bits. Address bit 1 selects the upper half, the data travels in bits 15:0, the other half of the register is kept, and a read returns zero in bits 31:16. Any access with address bit 0 set, or a wide access with address bit 1 set, is ignored and reads zero.
- R5: While the run bit is 1, the counter advances by one on each clock. While it is 0, the counter holds its value.
- R6: For a live period P, the counter counts 0 to P-1 and then returns to 0, giving P clocks per period. A period of 0 or 1 keeps the count at 0, and period 1 with compare 1 gives a constant active output.
- R7: With polarity 0 and mode 1, the output is high while the count is below the live compare value and low otherwise. A compare of 0 gives a constant low; a compare at or above the period gives a constant high.
- R8: With polarity 1 and mode 1, the output is the inverse of the R7 waveform, so the compare value sets the length of the low part.
- R9: With mode 0, the output is low whatever the count, compare and polarity are.
- R10: A write to a staged register marks that register pending. The live registers do not change until a clock edge where the counter is running and wraps. On that edge each pending staged value is copied into its live register and its pending mark is cleared. A staged write on a wrap edge waits for the following wrap. No transfer occurs while the counter is stopped.
- R11: A write to a live register takes effect on the next clock and cancels any pending transfer for that register only. This holds even when the write lands on a wrap edge.
- R12: The sync-select field is stored and read back but has no effect on the counter or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; counter and registers update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; one write per clock in which it is high |
| bus_addr | input | 6 | Byte address of the access |
| bus_wdata | input | 32 | Write data (16-bit accesses use bits 15:0) |
| bus_wide | input | 1 | 1 selects a 32-bit access, 0 a 16-bit access |
| bus_rdata | output | 32 | Read data, a combinational function of address, width and register contents |
| pwm_out | output | 1 | PWM waveform |

## Verification
A write is applied on the rising edge where `bus_wr` is sampled high. Its effect on the registers, the counter and `pwm_out` is visible from that edge on. Read data depends only on the address, the access width and the register state, so each read is checked a short delay after the address changes, with no clock edge in between. The output is a direct function of the registered count and the live registers, and it settles in the same cycle. The bench therefore steps a cycle model on every rising edge and compares `pwm_out` at the falling edge that follows, which catches a staged transfer on exactly the wrap edge and not one clock early or late.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    // register and bus geometry
    localparam int REG_W  = 32;
    localparam int CTRL_W = 16;
    localparam int HALF_W = REG_W / 2;
    localparam int ADDR_W = 6;

    // byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_PER_LIVE = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP_LIVE = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_PER_STG  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP_STG  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 6'h2A;

    // control bit positions
    localparam int CB_RUN  = 4;
    localparam int CB_SYNC = 6;
    localparam int CB_MODE = 9;
    localparam int CB_POL  = 10;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        CTRL_W'((1 << CB_RUN) | (3 << CB_SYNC) | (1 << CB_MODE) | (1 << CB_POL));

    typedef struct packed {
        logic [REG_W-1:0]  per;
        logic [REG_W-1:0]  cmp;
        logic [REG_W-1:0]  per_stg;
        logic [REG_W-1:0]  cmp_stg;
        logic              pend_per;
        logic              pend_cmp;
        logic [CTRL_W-1:0] ctrl;
    } apwm_regs_t;

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile
    import apwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wide,
    input  logic              boundary,
    output logic [REG_W-1:0]  per_live,
    output logic [REG_W-1:0]  cmp_live,
    output logic [CTRL_W-1:0] ctrl,
    output logic [REG_W-1:0]  rdata
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WD_PER  = OFS_PER_LIVE[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] WD_CMP  = OFS_CMP_LIVE[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] WD_PSTG = OFS_PER_STG[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] WD_CSTG = OFS_CMP_STG[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] WD_CTRL = OFS_CTRL[ADDR_W-1:2];

    apwm_regs_t regs_d, regs_q;

    logic [WORD_W-1:0] word;
    logic              hi_half;
    logic              acc_ok;
    logic              wr_ok;
    logic [REG_W-1:0]  rd_word;
    logic [CTRL_W-1:0] ctrl_wr;

    assign word    = addr[ADDR_W-1:2];
    assign hi_half = addr[1];
    assign acc_ok  = !addr[0] && (!wide || !addr[1]);
    assign wr_ok   = wr && acc_ok;
    assign ctrl_wr = wide ? wdata[REG_W-1:HALF_W] : wdata[CTRL_W-1:0];

    function automatic logic [REG_W-1:0] merge_wr(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic             full,
        input logic             upper
    );
        logic [REG_W-1:0] r;
        if (full)
            r = new_v;
        else if (upper)
            r = {new_v[HALF_W-1:0], old_v[HALF_W-1:0]};
        else
            r = {old_v[REG_W-1:HALF_W], new_v[HALF_W-1:0]};
        return r;
    endfunction

    always_comb begin
        regs_d = regs_q;
        // staged values move on a wrap edge of a running counter
        if (boundary) begin
            if (regs_q.pend_per) begin
                regs_d.per      = regs_q.per_stg;
                regs_d.pend_per = 1'b0;
            end
            if (regs_q.pend_cmp) begin
                regs_d.cmp      = regs_q.cmp_stg;
                regs_d.pend_cmp = 1'b0;
            end
        end
        // bus writes win over the transfer
        if (wr_ok) begin
            unique case (word)
                WD_PER: begin
                    regs_d.per      = merge_wr(regs_d.per, wdata, wide, hi_half);
                    regs_d.pend_per = 1'b0;
                end
                WD_CMP: begin
                    regs_d.cmp      = merge_wr(regs_d.cmp, wdata, wide, hi_half);
                    regs_d.pend_cmp = 1'b0;
                end
                WD_PSTG: begin
                    regs_d.per_stg  = merge_wr(regs_q.per_stg, wdata, wide, hi_half);
                    regs_d.pend_per = 1'b1;
                end
                WD_CSTG: begin
                    regs_d.cmp_stg  = merge_wr(regs_q.cmp_stg, wdata, wide, hi_half);
                    regs_d.pend_cmp = 1'b1;
                end
                WD_CTRL: begin
                    if (wide || hi_half)
                        regs_d.ctrl = ctrl_wr & CTRL_MASK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        unique case (word)
            WD_PER:  rd_word = regs_q.per;
            WD_CMP:  rd_word = regs_q.cmp;
            WD_PSTG: rd_word = regs_q.per_stg;
            WD_CSTG: rd_word = regs_q.cmp_stg;
            WD_CTRL: rd_word = {regs_q.ctrl, {HALF_W{1'b0}}};
            default: rd_word = '0;
        endcase
        if (!acc_ok)
            rdata = '0;
        else if (wide)
            rdata = rd_word;
        else if (hi_half)
            rdata = {{HALF_W{1'b0}}, rd_word[REG_W-1:HALF_W]};
        else
            rdata = {{HALF_W{1'b0}}, rd_word[HALF_W-1:0]};
    end

    assign per_live = regs_q.per;
    assign cmp_live = regs_q.cmp;
    assign ctrl     = regs_q.ctrl;

    logic wr_per_live;
    logic wr_cmp_live;
    assign wr_per_live = wr_ok && (word == WD_PER);
    assign wr_cmp_live = wr_ok && (word == WD_CMP);

    // R10: without a wrap or a live write, the live period keeps its value
    p_live_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !wr_per_live) |=> $stable(regs_q.per));

    // R10: a pending staged period lands on a wrap edge
    p_stage_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && regs_q.pend_per && !wr_per_live) |=> (regs_q.per == $past(regs_q.per_stg)));

    // R11: a full live-compare write lands at once and cancels the pending transfer
    p_direct_cmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp_live && wide) |=> (regs_q.cmp == $past(wdata) && !regs_q.pend_cmp));

endmodule

// File: rtl/apwm_counter.sv
module apwm_counter
    import apwm_pkg::*;
#(
    parameter int CNT_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             boundary
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             wrap;

    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    // the next count would reach the period (period 0 behaves like 1)
    assign wrap     = cnt_inc >= {1'b0, period};
    assign boundary = run && wrap;

    always_comb begin
        cnt_d = cnt_q;
        if (run)
            cnt_d = wrap ? '0 : cnt_inc[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt_q == '0));

endmodule

// File: rtl/apwm_wave.sv
module apwm_wave
    import apwm_pkg::*;
#(
    parameter int CNT_W = REG_W
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             mode,
    input  logic             pol,
    output logic             wave
);

    logic active;

    always_comb begin
        active = count < cmp;
        wave   = mode && (active ^ pol);
    end

endmodule

// File: rtl/apwm_shadow.sv
module apwm_shadow
    import apwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wide,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);

    logic [REG_W-1:0]  per_live;
    logic [REG_W-1:0]  cmp_live;
    logic [CTRL_W-1:0] ctrl;
    logic [REG_W-1:0]  count;
    logic              boundary;

    apwm_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wide     (bus_wide),
        .boundary (boundary),
        .per_live (per_live),
        .cmp_live (cmp_live),
        .ctrl     (ctrl),
        .rdata    (bus_rdata)
    );

    apwm_counter #(.CNT_W(REG_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl[CB_RUN]),
        .period   (per_live),
        .count    (count),
        .boundary (boundary)
    );

    apwm_wave #(.CNT_W(REG_W)) u_wave (
        .count (count),
        .cmp   (cmp_live),
        .mode  (ctrl[CB_MODE]),
        .pol   (ctrl[CB_POL]),
        .wave  (pwm_out)
    );

    // R9: mode cleared holds the pin low
    p_mode_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_MODE] |-> !pwm_out);

    // R1: first cycle out of reset the output is low
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !pwm_out);

endmodule

// File: tb/test_apwm_shadow.sv
module test_apwm_shadow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wide = 1'b1;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    apwm_shadow i_apwm_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wide  (bus_wide),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // cycle model
    logic [31:0] m_per, m_cmp, m_pstg, m_cstg, m_cnt;
    logic        m_pp, m_pc;
    logic [15:0] m_ctrl;

    localparam logic [15:0] RUN  = 16'h0010;
    localparam logic [15:0] SYNC = 16'h00C0;
    localparam logic [15:0] MODE = 16'h0200;
    localparam logic [15:0] POL  = 16'h0400;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit ok_acc(input logic [5:0] a, input logic w);
        return !a[0] && (!w || !a[1]);
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic w, input logic h);
        if (w) return n;
        if (h) return {n[15:0], o[15:0]};
        return {o[31:16], n[15:0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a, input logic w);
        logic [31:0] v;
        if (!ok_acc(a, w)) return 32'h0;
        case (a[5:2])
            4'h2:    v = m_per;
            4'h3:    v = m_cmp;
            4'h4:    v = m_pstg;
            4'h5:    v = m_cstg;
            4'hA:    v = {m_ctrl, 16'h0};
            default: v = 32'h0;
        endcase
        if (w) return v;
        return a[1] ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
    endfunction

    function automatic logic exp_out();
        if (!m_ctrl[9]) return 1'b0;
        return (m_cnt < m_cmp) ^ m_ctrl[10];
    endfunction

    task automatic model_step();
        logic [32:0] nxt;
        bit run, bnd;
        nxt = {1'b0, m_cnt} + 33'd1;
        run = m_ctrl[4];
        bnd = run && (nxt >= {1'b0, m_per});
        if (bnd && m_pp) begin m_per = m_pstg; m_pp = 0; end
        if (bnd && m_pc) begin m_cmp = m_cstg; m_pc = 0; end
        if (bus_wr && ok_acc(bus_addr, bus_wide)) begin
            case (bus_addr[5:2])
                4'h2: begin m_per  = mrg(m_per,  bus_wdata, bus_wide, bus_addr[1]); m_pp = 0; end
                4'h3: begin m_cmp  = mrg(m_cmp,  bus_wdata, bus_wide, bus_addr[1]); m_pc = 0; end
                4'h4: begin m_pstg = mrg(m_pstg, bus_wdata, bus_wide, bus_addr[1]); m_pp = 1; end
                4'h5: begin m_cstg = mrg(m_cstg, bus_wdata, bus_wide, bus_addr[1]); m_pc = 1; end
                4'hA: if (bus_wide || bus_addr[1])
                          m_ctrl = (bus_wide ? bus_wdata[31:16] : bus_wdata[15:0]) & 16'h06D0;
                default: ;
            endcase
        end
        if (run) m_cnt = bnd ? 32'h0 : nxt[31:0];
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(pwm_out === exp_out(), cur_req, {31'h0, pwm_out}, {31'h0, exp_out()});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic w);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic ctrl_set(input logic [15:0] v);
        wr(6'h2A, {16'h0, v}, 1'b0);
    endtask

    task automatic rd(input logic [5:0] a, input logic w, input string req);
        bus_addr = a; bus_wide = w;
        #1;
        chk(bus_rdata === exp_read(a, w), req, bus_rdata, exp_read(a, w));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_per = 0; m_cmp = 0; m_pstg = 0; m_cstg = 0; m_cnt = 0;
        m_pp = 0; m_pc = 0; m_ctrl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(pwm_out === 1'b0, "R1", {31'h0, pwm_out}, 32'h0);
        foreach (m_ctrl[k]) ;
        rd(6'h08, 1, "R1"); rd(6'h0C, 1, "R1"); rd(6'h10, 1, "R1");
        rd(6'h14, 1, "R1"); rd(6'h2A, 0, "R1");
        ticks(4);

        // R2: live and staged registers, full-width accesses
        cur_req = "R2";
        wr(6'h08, 32'hA5A5_0003, 1); wr(6'h0C, 32'h1234_5678, 1);
        wr(6'h10, 32'h0BAD_F00D, 1); wr(6'h14, 32'hCAFE_0001, 1);
        rd(6'h08, 1, "R2"); rd(6'h0C, 1, "R2"); rd(6'h10, 1, "R2"); rd(6'h14, 1, "R2");
        wr(6'h20, 32'hFFFF_FFFF, 1); rd(6'h20, 1, "R2"); rd(6'h04, 1, "R2");

        // R3: control mask
        cur_req = "R3";
        ctrl_set(16'hF92F);
        rd(6'h2A, 0, "R3");
        chk(bus_rdata === 32'h0000_0000 + (16'hF92F & 16'h06D0), "R3", bus_rdata, 32'h0000_0000 + (16'hF92F & 16'h06D0));
        ctrl_set(16'h0000);

        // R4: half-word and misaligned accesses
        cur_req = "R4";
        wr(6'h12, 32'hFFFF_4321, 0); rd(6'h12, 0, "R4"); rd(6'h10, 0, "R4"); rd(6'h10, 1, "R4");
        wr(6'h08, 32'h0000_0007, 0); rd(6'h08, 1, "R4");
        wr(6'h0A, 32'h0000_0000, 0); rd(6'h08, 1, "R4");
        wr(6'h0D, 32'h0000_00FF, 0); rd(6'h0C, 1, "R4"); rd(6'h0D, 0, "R4");
        wr(6'h0E, 32'h0000_0000, 1); rd(6'h0E, 1, "R4"); rd(6'h0C, 1, "R4");
        wr(6'h28, {16'h0600, 16'h0000}, 1); rd(6'h28, 1, "R4"); rd(6'h2A, 0, "R4");
        wr(6'h28, 32'h0000_FFFF, 0); rd(6'h2A, 0, "R4");
        ctrl_set(16'h0000);

        // R5: run and hold
        cur_req = "R5";
        wr(6'h08, 32'd5, 1); wr(6'h0C, 32'd3, 1);
        ctrl_set(MODE | RUN); ticks(12);
        ctrl_set(MODE); ticks(6);
        ctrl_set(MODE | RUN); ticks(7);

        // R6: minimal and zero period
        cur_req = "R6";
        wr(6'h08, 32'd1, 1); wr(6'h0C, 32'd1, 1); ticks(5);
        chk(pwm_out === 1'b1, "R6", {31'h0, pwm_out}, 32'h1);
        wr(6'h08, 32'd0, 1); ticks(4);
        wr(6'h08, 32'd4, 1); wr(6'h0C, 32'd2, 1); ticks(10);

        // R7: compare corners
        cur_req = "R7";
        wr(6'h0C, 32'd0, 1); ticks(9);
        wr(6'h0C, 32'd4, 1); ticks(9);
        wr(6'h0C, 32'd9, 1); ticks(5);
        wr(6'h08, 32'd6, 1); wr(6'h0C, 32'd2, 1); ticks(13);

        // R8: inverted polarity
        cur_req = "R8";
        ctrl_set(MODE | RUN | POL); ticks(13);
        wr(6'h0C, 32'd0, 1); ticks(7);

        // R9: mode off
        cur_req = "R9";
        ctrl_set(RUN | POL); ticks(8);
        ctrl_set(RUN); wr(6'h0C, 32'd3, 1); ticks(8);

        // R10: staged update mid-period and while stopped
        cur_req = "R10";
        wr(6'h08, 32'd8, 1); wr(6'h0C, 32'd4, 1);
        ctrl_set(MODE | RUN); ticks(3);
        wr(6'h10, 32'd3, 1); wr(6'h14, 32'd1, 1); ticks(14);
        ctrl_set(MODE);
        wr(6'h14, 32'd3, 1); ticks(8);
        ctrl_set(MODE | RUN); ticks(8);

        // R11: live write cancels pending transfer
        cur_req = "R11";
        wr(6'h08, 32'd10, 1); wr(6'h0C, 32'd5, 1); ticks(2);
        wr(6'h14, 32'd2, 1); wr(6'h0C, 32'd7, 1); ticks(25);
        rd(6'h0C, 1, "R11");

        // R12: sync-select has no effect
        cur_req = "R12";
        ctrl_set(MODE | RUN | SYNC); rd(6'h2A, 0, "R12"); ticks(12);
        ctrl_set(MODE | RUN); ticks(12);

        // random mix of writes, reads and idle cycles
        cur_req = "R10";
        for (int it = 0; it < 3000; it++) begin
            int r;
            logic [5:0] a;
            r = $urandom % 10;
            case ($urandom % 12)
                0: a = 6'h08;  1: a = 6'h0A;  2: a = 6'h0C;  3: a = 6'h0E;
                4: a = 6'h10;  5: a = 6'h12;  6: a = 6'h14;  7: a = 6'h16;
                8: a = 6'h28;  9: a = 6'h2A;  10: a = 6'h2B; default: a = 6'h04;
            endcase
            if (r < 4) tick();
            else if (r < 8) begin
                if (a == 6'h2A || a == 6'h28)
                    wr(a, {$urandom % 65536, $urandom % 65536} | 32'h0010_0010, $urandom % 2);
                else
                    wr(a, $urandom % 12, $urandom % 2);
            end
            else rd(a, $urandom % 2, "R2");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule